// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte-Lane Writes

A synchronous single-port memory with a parameterised depth and four 9-bit byte lanes. Every control input is taken on the rising clock edge. One of two address strobes opens an access: the processor-side strobe and the controller-side strobe. A three-input chip select gates both strobes. Once an address is taken, its upper bits stay fixed. Its two lowest bits seed a 2-bit burst counter, and an advance input steps that counter through the four words of an aligned group.

Writes either fill every lane through a global write enable, or fill selected lanes through a byte write enable and per-lane selects. Read data is pipelined through a RAM register and an output register. An asynchronous active-low output enable qualifies the output-valid flag, which stands in for the pad drive. The data pins are modelled as separate data-in, data-out and output-valid signals. After reset or a deselect, the first read beat is kept off the output.

Top module: `burst_sram`

## Requirements
- R1: The chip counts as selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. A counted strobe edge while not selected makes no access, ends any burst, and yields `dout_vld`=0 from the third rising edge onward.
- R2: `ads_cpu_n` is ignored while `sel1_n`=1. With no burst running, it makes no access. With a burst running, the burst goes on as if no strobe were present.
- R3: A selected edge with `ads_cpu_n`=0 and `sel1_n`=0 captures `addr` and performs a read, whatever the write enables are doing.
- R4: A selected edge with only `ads_ctl_n`=0 captures `addr` and performs a write if a write is requested, else a read. While a burst runs with no strobe, every edge is such an access at the burst address.
- R5: On a capture, `addr[1:0]` loads the burst counter and the remaining bits are held for the burst. On an in-burst edge with `adv_n`=0, the counter steps modulo 4 before the access (…,3,0,…), and the upper bits do not change.
- R6: `gwe_n`=0 on a write access writes all four lanes, whatever `bwe_n` and `lane_n` are.
- R7: With `gwe_n`=1 and `bwe_n`=0, only lanes whose `lane_n[i]`=0 are written (lane i is `din[9i+8:9i]`). With `gwe_n`=1 and either `bwe_n`=1 or `lane_n`=4'hF, the access is a read and nothing is written.
- R8: Read data appears on `dout` after the second rising edge following the access edge. A read sees every earlier write.
- R9: `oe_n`=1 forces `dout_vld`=0 at once, without waiting for a clock edge.
- R10: The first read access after reset or after a deselect keeps `dout_vld`=0 for its beat. Any access clears this condition.
- R11: After reset, and whenever no access happened two edges earlier, `dout_vld`=0. After reset, `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address, taken on a strobe |
| ads_cpu_n | input | 1 | Processor address strobe, active low |
| ads_ctl_n | input | 1 | Controller address strobe, active low |
| sel1_n | input | 1 | Chip select 1, active low |
| sel2 | input | 1 | Chip select 2, active high |
| sel3_n | input | 1 | Chip select 3, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwe_n | input | 1 | Global write enable, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| lane_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Registered read data |
| dout_vld | output | 1 | Output would be driven on the pads |

## Verification
The properties assume that the controls are clean, known levels at each rising edge. They also assume that `oe_n` changes only away from the edges, so its asynchronous path is seen settled. The stimulus changes every input one time unit after an edge and holds it for the rest of the cycle. It opens with a full-memory fill, so that no read ever returns undefined contents. The random phase keeps the chip selected most of the time, so that bursts grow long and the counter wraps. Deselects and ignored processor strobes still occur often enough to end bursts and to re-arm the first-beat mask.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;
endpackage

// File: rtl/burst_count.sv
module burst_count #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] seed,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= seed;
    else if (step) cnt <= cnt + ONE;
  end
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int BASE_W = ADDR_W - BURST_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ads_cpu_n,
  input  logic              ads_ctl_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              adv_n,
  input  logic              gwe_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic [DATA_W-1:0] din,
  output acc_e              acc_kind,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [LANES-1:0]  acc_mask,
  output logic [DATA_W-1:0] acc_data,
  output logic              acc_first,
  output logic              burst_on
);
  logic               chip_sel, cpu_go, ctl_go, start;
  logic               do_load, do_step, do_acc, do_wr;
  logic               fresh_q;
  logic [LANES-1:0]   lane_req;
  logic [BASE_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;

  assign chip_sel = !sel1_n && sel2 && !sel3_n;
  assign cpu_go   = !ads_cpu_n && !sel1_n;
  assign ctl_go   = !ads_ctl_n;
  assign start    = cpu_go || ctl_go;

  // global write wins over the per-lane path
  assign lane_req = !gwe_n ? '1 : (!bwe_n ? ~lane_n : '0);

  assign do_load = start && chip_sel;
  assign do_step = !start && burst_on && !adv_n;
  assign do_acc  = do_load || (!start && burst_on);
  assign do_wr   = do_acc && (|lane_req) && !cpu_go;

  burst_count #(.W(BURST_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .load (do_load),
    .step (do_step),
    .seed (addr[BURST_W-1:0]),
    .cnt  (cnt_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_on  <= 1'b0;
      base_q    <= '0;
      fresh_q   <= 1'b1;
      acc_kind  <= ACC_NONE;
      acc_mask  <= '0;
      acc_data  <= '0;
      acc_first <= 1'b0;
    end else begin
      if (start)   burst_on <= chip_sel;
      if (do_load) base_q   <= addr[ADDR_W-1:BURST_W];
      if (start && !chip_sel) fresh_q <= 1'b1;
      else if (do_acc)        fresh_q <= 1'b0;
      acc_kind  <= !do_acc ? ACC_NONE : (do_wr ? ACC_WRITE : ACC_READ);
      acc_mask  <= do_wr ? lane_req : '0;
      acc_data  <= din;
      acc_first <= do_acc && !do_wr && fresh_q;
    end
  end

  assign acc_addr = {base_q, cnt_q};
endmodule

// File: rtl/lane_ram.sv
module lane_ram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  acc_e              acc_kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  mask,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q_l;

    always_ff @(posedge clk) begin
      if (acc_kind == ACC_WRITE && mask[l])
        mem[addr] <= wdata[l*LANE_W +: LANE_W];
      q_l <= mem[addr];
    end

    assign q[l*LANE_W +: LANE_W] = q_l;
  end
endmodule

// File: rtl/out_stage.sv
module out_stage
  import burst_sram_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_e              acc_kind,
  input  logic              acc_first,
  input  logic [DATA_W-1:0] q,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_vld
);
  logic rd1, first1, vld2, first2;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd1    <= 1'b0;
      first1 <= 1'b0;
      vld2   <= 1'b0;
      first2 <= 1'b0;
      dout   <= '0;
    end else begin
      rd1    <= (acc_kind == ACC_READ);
      first1 <= acc_first;
      vld2   <= rd1;
      first2 <= first1;
      if (rd1) dout <= q;
    end
  end

  // output enable acts without a clock
  assign dout_vld = vld2 && !first2 && !oe_n;
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ads_cpu_n,
  input  logic              ads_ctl_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              adv_n,
  input  logic              gwe_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_vld
);
  acc_e              acc_kind;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  acc_mask;
  logic [DATA_W-1:0] acc_data;
  logic              acc_first;
  logic              burst_on;
  logic [DATA_W-1:0] ram_q;

  burst_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .ads_cpu_n (ads_cpu_n),
    .ads_ctl_n (ads_ctl_n),
    .sel1_n    (sel1_n),
    .sel2      (sel2),
    .sel3_n    (sel3_n),
    .adv_n     (adv_n),
    .gwe_n     (gwe_n),
    .bwe_n     (bwe_n),
    .lane_n    (lane_n),
    .din       (din),
    .acc_kind  (acc_kind),
    .acc_addr  (acc_addr),
    .acc_mask  (acc_mask),
    .acc_data  (acc_data),
    .acc_first (acc_first),
    .burst_on  (burst_on)
  );

  lane_ram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_ram (
    .clk      (clk),
    .acc_kind (acc_kind),
    .addr     (acc_addr),
    .mask     (acc_mask),
    .wdata    (acc_data),
    .q        (ram_q)
  );

  out_stage #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .acc_kind  (acc_kind),
    .acc_first (acc_first),
    .q         (ram_q),
    .oe_n      (oe_n),
    .dout      (dout),
    .dout_vld  (dout_vld)
  );
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              ads_cpu_n,
  input logic              ads_ctl_n,
  input logic              sel1_n,
  input logic              sel2,
  input logic              sel3_n,
  input logic              adv_n,
  input logic              gwe_n,
  input logic              bwe_n,
  input logic              oe_n,
  input logic              dout_vld,
  input acc_e              acc_kind,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [LANES-1:0]  acc_mask,
  input logic              burst_on
);
  logic sel_ok, cpu_seen, ctl_seen;
  assign sel_ok   = !sel1_n && sel2 && !sel3_n;
  assign cpu_seen = !ads_cpu_n && !sel1_n;
  assign ctl_seen = !ads_ctl_n;

  // R9
  oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    dout_vld |-> !oe_n);

  // R1
  desel_drain_chk: assert property (@(posedge clk) disable iff (rst)
    ((cpu_seen || ctl_seen) && !sel_ok) |-> ##3 !dout_vld);

  // R3
  cpu_read_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_seen && sel_ok) |=> (acc_kind == ACC_READ));

  // R2
  cpu_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (sel1_n && ads_ctl_n && !burst_on) |=> (acc_kind == ACC_NONE));

  // R6
  gw_all_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_seen && !cpu_seen && sel_ok && !gwe_n) |=> (acc_kind == ACC_WRITE && &acc_mask));

  // R7
  no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (gwe_n && bwe_n) |=> (acc_kind != ACC_WRITE));

  // R5
  burst_step_chk: assert property (@(posedge clk) disable iff (rst)
    (burst_on && !ctl_seen && !cpu_seen && !adv_n) |=>
      (acc_addr[1:0] == $past(acc_addr[1:0]) + 2'd1 &&
       acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2])));
endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ads_cpu_n (ads_cpu_n),
  .ads_ctl_n (ads_ctl_n),
  .sel1_n    (sel1_n),
  .sel2      (sel2),
  .sel3_n    (sel3_n),
  .adv_n     (adv_n),
  .gwe_n     (gwe_n),
  .bwe_n     (bwe_n),
  .oe_n      (oe_n),
  .dout_vld  (dout_vld),
  .acc_kind  (acc_kind),
  .acc_addr  (acc_addr),
  .acc_mask  (acc_mask),
  .burst_on  (burst_on)
);

// File: tb/sim_burst_sram.sv
`timescale 1ns/1ps
module sim_burst_sram;
  localparam int AW = 8;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          ads_cpu_n = 1'b1, ads_ctl_n = 1'b1;
  logic          sel1_n = 1'b0, sel2 = 1'b1, sel3_n = 1'b0;
  logic          adv_n = 1'b1, gwe_n = 1'b1, bwe_n = 1'b1;
  logic [NL-1:0] lane_n = '1;
  logic          oe_n = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_vld;

  always #5 clk = ~clk;

  burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .ads_cpu_n(ads_cpu_n), .ads_ctl_n(ads_ctl_n),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n), .adv_n(adv_n), .gwe_n(gwe_n),
    .bwe_n(bwe_n), .lane_n(lane_n), .oe_n(oe_n), .din(din), .dout(dout), .dout_vld(dout_vld)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R11";
  bit    running = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [DW-1:0] mem_m [1 << AW];
  bit            act_m, fresh_m;
  int            up_m, cnt_m;
  bit            s0v, s0f, s1v, s1f, ov, of;
  logic [DW-1:0] s0d, s1d, od;

  always @(posedge clk) begin
    if (rst) begin
      act_m = 0; fresh_m = 1; s0v = 0; s1v = 0; ov = 0; of = 0;
      up_m = 0; cnt_m = 0;
    end else begin
      bit sel, cs, ks, doacc, iswr;
      logic [NL-1:0] lanes;
      int a;
      ov = s1v; of = s1f; od = s1d;
      s1v = s0v; s1f = s0f; s1d = s0d;
      s0v = 0; s0f = 0;
      sel = !sel1_n && sel2 && !sel3_n;
      cs  = !ads_cpu_n && !sel1_n;
      ks  = !ads_ctl_n;
      lanes = '0;
      for (int l = 0; l < NL; l++)
        if (!gwe_n || (!bwe_n && !lane_n[l])) lanes[l] = 1'b1;
      doacc = 0; iswr = 0;
      if (cs || ks) begin
        if (sel) begin
          act_m = 1; up_m = int'(addr) / 4; cnt_m = int'(addr) % 4;
          doacc = 1; iswr = !cs && (lanes != '0);
        end else begin
          act_m = 0; fresh_m = 1;
        end
      end else if (act_m) begin
        if (!adv_n) cnt_m = (cnt_m + 1) % 4;
        doacc = 1; iswr = (lanes != '0);
      end
      if (doacc) begin
        a = up_m * 4 + cnt_m;
        if (iswr) begin
          for (int l = 0; l < NL; l++)
            if (lanes[l]) mem_m[a][l*LW +: LW] = din[l*LW +: LW];
        end else begin
          s0v = 1; s0f = fresh_m; s0d = mem_m[a];
        end
        fresh_m = 0;
      end
    end
  end

  // compare on every cycle, away from the rising edge
  always @(negedge clk) begin
    if (running && !rst) begin
      bit ev;
      ev = ov && !of && !oe_n;
      chk(dout_vld === ev, cur_req, "dout_vld", DW'(dout_vld), DW'(ev));
      if (ev) chk(dout === od, cur_req, "dout", dout, od);
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    ads_cpu_n = 1; ads_ctl_n = 1; adv_n = 1; gwe_n = 1; bwe_n = 1;
    lane_n = '1; sel1_n = 0; sel2 = 1; sel3_n = 0; oe_n = 0;
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return {NL{9'(a ^ 9'h0AB)}} ^ 36'h123456789;
  endfunction

  task automatic deselect();
    quiet(); ads_ctl_n = 0; sel2 = 0; tick();
    quiet();
  endtask

  initial begin
    quiet();
    repeat (3) tick();
    rst = 0;
    @(negedge clk);
    // R11: reset state at the ports
    chk(dout_vld === 1'b0, "R11", "reset dout_vld", DW'(dout_vld), '0);
    chk(dout === '0, "R11", "reset dout", dout, '0);
    running = 1;
    tick();

    // R6: fill memory with global-write bursts (byte controls set against it)
    cur_req = "R6";
    for (int b = 0; b < (1 << AW) / 4; b++) begin
      for (int k = 0; k < 4; k++) begin
        quiet();
        gwe_n = 0; bwe_n = 1; lane_n = 4'b0101;
        if (k == 0) begin ads_ctl_n = 0; addr = AW'(b * 4); end
        else adv_n = 0;
        din = pat(b * 4 + k);
        tick();
      end
    end
    quiet(); tick(); tick();

    // R1: deselect ends the burst, output drains
    cur_req = "R1";
    deselect();
    repeat (4) tick();

    // R3 / R5 / R10 / R8: processor read burst starting mid-group, wrapping
    cur_req = "R5";
    quiet(); ads_cpu_n = 0; gwe_n = 0; addr = 8'h12; tick();
    quiet(); gwe_n = 1;
    for (int k = 0; k < 5; k++) begin adv_n = 0; tick(); end
    cur_req = "R8";
    quiet(); tick(); tick();
    cur_req = "R3";
    deselect(); ads_cpu_n = 0; addr = 8'h31; tick();
    cur_req = "R10";
    quiet(); adv_n = 0; tick(); tick();
    quiet(); repeat (3) tick();

    // R7: lane writes, then a write request with no lanes reads instead
    cur_req = "R7";
    quiet(); ads_ctl_n = 0; addr = 8'h40; bwe_n = 0; lane_n = 4'b1010;
    din = 36'hFEDCBA987; tick();
    quiet(); adv_n = 0; bwe_n = 0; lane_n = 4'b0110; din = 36'h0F0F0F0F0; tick();
    quiet(); adv_n = 0; bwe_n = 0; lane_n = 4'hF; din = 36'h111111111; tick();
    quiet(); adv_n = 0; bwe_n = 1; lane_n = 4'h0; din = 36'h222222222; tick();
    quiet(); ads_cpu_n = 0; addr = 8'h40; tick();
    quiet(); for (int k = 0; k < 4; k++) begin adv_n = 0; tick(); end
    quiet(); tick(); tick();

    // R4: controller strobe read, then write inside the burst
    cur_req = "R4";
    quiet(); ads_ctl_n = 0; addr = 8'h83; tick();
    quiet(); adv_n = 0; gwe_n = 0; din = 36'hABCDE1234; tick();
    quiet(); ads_cpu_n = 0; addr = 8'h80; tick();
    quiet(); repeat (4) begin adv_n = 0; tick(); end
    quiet(); tick(); tick();

    // R2: ignored processor strobe during and outside a burst
    cur_req = "R2";
    quiet(); ads_cpu_n = 0; addr = 8'h50; tick();
    quiet(); ads_cpu_n = 0; sel1_n = 1; adv_n = 0; addr = 8'hF0; tick();
    quiet(); ads_cpu_n = 0; sel1_n = 1; adv_n = 0; addr = 8'hF0; tick();
    deselect();
    quiet(); ads_cpu_n = 0; sel1_n = 1; repeat (4) tick();

    // R9: asynchronous output enable during a read burst
    cur_req = "R9";
    quiet(); ads_cpu_n = 0; addr = 8'h64; tick();
    quiet();
    for (int k = 0; k < 8; k++) begin adv_n = 0; oe_n = k[0]; tick(); end
    quiet(); tick(); tick();

    // R4: mixed random traffic
    cur_req = "R4";
    for (int n = 0; n < 600; n++) begin
      int r;
      r = int'($urandom % 16);
      ads_cpu_n = (r != 0);
      ads_ctl_n = !(r == 1 || r == 2);
      sel1_n = ($urandom % 10 == 0);
      sel2   = ($urandom % 10 != 0);
      sel3_n = ($urandom % 10 == 0);
      adv_n  = $urandom % 2 == 0;
      gwe_n  = ($urandom % 4 != 0);
      bwe_n  = $urandom % 2 == 0;
      lane_n = NL'($urandom);
      oe_n   = ($urandom % 6 == 0);
      addr   = AW'($urandom);
      din    = DW'({$urandom, $urandom});
      tick();
    end
    quiet(); repeat (4) tick();

    running = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule